// File: doc/BRIEF.md
# Data Termination Disable Controller

This block drives the enable for the on-die termination of a graphics DRAM's data pins. It watches a decoded command code and one active-low chip select per rank on every rising clock edge. A read, or a command that exists only to switch the data terminators off, starts a window in which the termination is released so that the bus can be driven. The command may be addressed to this device's rank or to any other rank on the shared bus. Each window opens CL−1 edges after the triggering edge and stays open for four clocks, where CL is the programmed CAS latency.

Several triggering commands can be in flight at the same time. The block keeps a shift map of future disabled cycles and merges each new window into it, so the termination stays off whenever any window covers a cycle. The CAS latency input is taken only while nothing is pending, so changing it cannot cut an open window short. The address/command termination enable is a separate output that is always asserted.

Top module: `dterm_ctrl`

## Requirements
- R1: A command code of 3'd1 (read) or 3'd3 (termination off) sampled on a rising edge with at least one chip select low starts a disable window.
- R2: For a trigger sampled at edge t, `dataTermEn` is 0 after edges t+CL−1 through t+CL+2 and returns to 1 after edge t+CL+3 if no other window covers that edge. With CL = 7 and a read at edge 0, it is 0 after edges 6, 7, 8 and 9.
- R3: A trigger is accepted whichever rank's chip select is low (`csN` = 2'b10, 2'b01 or 2'b00).
- R4: Command codes 0, 2, 4, 5, 6 and 7, and any command with all chip selects high (`csN` = 2'b11), leave `dataTermEn` unchanged.
- R5: Overlapping or back-to-back windows combine. `dataTermEn` is 0 after every edge that any pending window covers.
- R6: `cmdTermEn` is 1 at all times, including during reset.
- R7: `casLat` is captured at an edge only if no window disabled the output in the cycle just ending and none is scheduled for that edge or later. Otherwise the most recently captured value times any new trigger.
- R8: `casLat` values below 5 are treated as 5, and values above 12 are treated as 12.
- R9: While `rstN` is low, all pending windows are cleared and `dataTermEn` is 1. After release, no earlier command has any effect.
- R10: `dataTermEn` is a register output and changes only on a rising clock edge or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCode | input | 3 | Decoded command code (1 = read, 3 = termination off) |
| csN | input | 2 | Active-low chip select, one bit per rank |
| casLat | input | 4 | Programmed CAS latency, 5 to 12 |
| dataTermEn | output | 1 | Data-pin termination enable, 0 while a window is open |
| cmdTermEn | output | 1 | Address/command termination enable, always 1 |

## Verification
Two events can fall on the same edge. A new trigger can arrive while an earlier window is still pending, and the latency input can change on the very edge where that trigger is sampled. The bench issues reads on consecutive edges and at short gaps at the shortest latency, so the windows overlap or touch. It also raises the latency to 12 in the same cycle as a read that lands inside a pending window. A behavioural model tracks every window as a start/end pair of absolute edge numbers, together with its own captured latency, and it predicts the output after each edge. That prediction is compared with `dataTermEn` after every clock. Any merge gap, a window that gets shortened, or a latency captured too early shows up as a mismatch on a specific edge.

// File: rtl/dterm_pkg.sv
package dterm_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_TOFF  = 3'd3,
    CMD_ACT   = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_REF   = 3'd6,
    CMD_MODE  = 3'd7
  } cmd_e;

  // strobes from the command decode to the window datapath
  typedef struct packed {
    logic fire;       // a termination-off window must be queued
    logic sampleLat;  // no window pending: latency input may be captured
  } ctl_strobe_t;
endpackage

// File: rtl/dterm_cmd_decode.sv
module dterm_cmd_decode
  import dterm_pkg::*;
#(
  parameter int NUM_RANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CMD_W-1:0]     cmdCode,
  input  logic [NUM_RANKS-1:0] csN,
  input  logic                 winBusy,
  output ctl_strobe_t          strobes
);
  logic                 isTrigCmd;
  logic [NUM_RANKS-1:0] rankHit;

  always_comb isTrigCmd = (cmdCode == CMD_READ) || (cmdCode == CMD_TOFF);

  // every rank on the shared bus is snooped
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign rankHit[r] = isTrigCmd & ~csN[r];
  end

  always_comb begin
    strobes.fire      = |rankHit;
    strobes.sampleLat = !winBusy;
  end

  // R4: a deselected bus never queues a window
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> !strobes.fire);

  // R4: non-trigger codes never queue a window
  p_other_cmd_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !((cmdCode == CMD_READ) || (cmdCode == CMD_TOFF)) |-> !strobes.fire);
endmodule

// File: rtl/dterm_window_path.sv
module dterm_window_path
  import dterm_pkg::*;
#(
  parameter int MIN_CL  = 5,
  parameter int MAX_CL  = 12,
  parameter int WIN_LEN = 4,
  parameter int LAT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strobes,
  input  logic [LAT_W-1:0] casLat,
  output logic             winBusy,
  output logic             dataTermEn
);
  // latest disabled edge offset is MAX_CL-1+WIN_LEN-1
  localparam int MAP_W = MAX_CL + WIN_LEN - 1;
  localparam logic [LAT_W-1:0] MIN_V = LAT_W'(MIN_CL);
  localparam logic [LAT_W-1:0] MAX_V = LAT_W'(MAX_CL);

  logic [LAT_W-1:0] latClamped, latHeld, latUse;
  logic [MAP_W-1:0] offMap, offNext, winMask;

  always_comb begin
    if (casLat < MIN_V)      latClamped = MIN_V;
    else if (casLat > MAX_V) latClamped = MAX_V;
    else                     latClamped = casLat;
  end

  always_comb latUse = strobes.sampleLat ? latClamped : latHeld;

  // bit i set means "disabled after the edge i cycles from now"
  always_comb begin
    for (int i = 0; i < MAP_W; i++) begin
      winMask[i] = (i + 1 >= int'(latUse)) && (i + 2 <= int'(latUse) + WIN_LEN);
    end
  end

  always_comb offNext = (offMap >> 1) | (strobes.fire ? winMask : '0);
  always_comb winBusy = |offMap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offMap     <= '0;
      latHeld    <= MIN_V;
      dataTermEn <= 1'b1;
    end else begin
      offMap     <= offNext;
      dataTermEn <= ~offNext[0];
      if (strobes.sampleLat) latHeld <= latClamped;
    end
  end

  // R1: a trigger always leaves work queued
  p_window_queued_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |=> winBusy);

  // R2: from idle, the first four edges after a trigger stay enabled (CL >= 5)
  p_no_early_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fire && strobes.sampleLat) |=> dataTermEn ##1 dataTermEn ##1 dataTermEn ##1 dataTermEn);

  // R2/R5: every disabled stretch is at least four clocks
  p_min_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataTermEn) |=> !dataTermEn ##1 !dataTermEn ##1 !dataTermEn);

  // R7: captured latency frozen while work is pending
  p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    winBusy |=> $stable(latHeld));
endmodule

// File: rtl/dterm_ctrl.sv
module dterm_ctrl
  import dterm_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int MIN_CL    = 5,
  parameter int MAX_CL    = 12,
  parameter int WIN_LEN   = 4,
  parameter int LAT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CMD_W-1:0]     cmdCode,
  input  logic [NUM_RANKS-1:0] csN,
  input  logic [LAT_W-1:0]     casLat,
  output logic                 dataTermEn,
  output logic                 cmdTermEn
);
  ctl_strobe_t strobes;
  logic        winBusy;

  dterm_cmd_decode #(.NUM_RANKS(NUM_RANKS)) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .cmdCode (cmdCode),
    .csN     (csN),
    .winBusy (winBusy),
    .strobes (strobes)
  );

  dterm_window_path #(
    .MIN_CL (MIN_CL),
    .MAX_CL (MAX_CL),
    .WIN_LEN(WIN_LEN),
    .LAT_W  (LAT_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .casLat    (casLat),
    .winBusy   (winBusy),
    .dataTermEn(dataTermEn)
  );

  // R6: address/command termination never switches
  assign cmdTermEn = 1'b1;
endmodule

// File: tb/dterm_ctrl_test.sv
`timescale 1ns/1ps
module dterm_ctrl_test;
  import dterm_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [1:0] csN = 2'b11;
  logic [3:0] casLat = 4'd7;
  logic       dataTermEn, cmdTermEn;

  int    checks = 0;
  int    errors = 0;
  string phaseTag = "R9";

  int edgeNo = 0;
  int heldLat = 5;
  int wStart[$];
  int wEnd[$];
  bit expEn = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  dterm_ctrl uut (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .csN(csN),
    .casLat(casLat), .dataTermEn(dataTermEn), .cmdTermEn(cmdTermEn)
  );

  function automatic int clampLat(input int v);
    if (v < 5) return 5;
    if (v > 12) return 12;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d at edge %0d", req, what, act, exp, edgeNo);
    end
  endtask

  // behavioural reference: windows as absolute edge ranges
  always @(posedge clk) begin
    if (!rstN) begin
      wStart.delete();
      wEnd.delete();
      expEn = 1'b1;
      heldLat = 5;
    end else begin
      bit busy;
      int eff;
      busy = 1'b0;
      foreach (wEnd[i]) if (wEnd[i] >= edgeNo - 1) busy = 1'b1;
      eff = busy ? heldLat : clampLat(int'(casLat));
      if (!busy) heldLat = clampLat(int'(casLat));
      if ((cmdCode == CMD_READ || cmdCode == CMD_TOFF) && csN != 2'b11) begin
        wStart.push_back(edgeNo + eff - 1);
        wEnd.push_back(edgeNo + eff + 2);
      end
      expEn = 1'b1;
      foreach (wStart[i]) if (wStart[i] <= edgeNo && edgeNo <= wEnd[i]) expEn = 1'b0;
    end
    #1;
    check(dataTermEn === expEn, phaseTag, "dataTermEn", int'(dataTermEn), int'(expEn));
    check(cmdTermEn === 1'b1, "R6", "cmdTermEn", int'(cmdTermEn), 1);
    edgeNo++;
  end

  task automatic issue(input logic [2:0] c, input logic [1:0] cs);
    @(negedge clk);
    cmdCode = c;
    csN = cs;
  endtask

  task automatic idle(input int n);
    repeat (n) issue(CMD_NOP, 2'b11);
  endtask

  initial begin
    // R9: reset state
    phaseTag = "R9";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R2 / R10: single read, CL = 7, low after edges t+6..t+9
    phaseTag = "R2";
    casLat = 4'd7;
    issue(CMD_READ, 2'b10);
    idle(16);

    // R1: termination-off command
    phaseTag = "R1";
    issue(CMD_TOFF, 2'b10);
    idle(16);

    // R3: other rank and both ranks
    phaseTag = "R3";
    issue(CMD_READ, 2'b01);
    idle(16);
    issue(CMD_TOFF, 2'b01);
    idle(16);
    issue(CMD_READ, 2'b00);
    idle(16);

    // R4: non-trigger codes and deselected triggers
    phaseTag = "R4";
    for (int k = 0; k < 8; k++) if (k != 1 && k != 3) issue(3'(k), 2'b00);
    issue(CMD_READ, 2'b11);
    issue(CMD_TOFF, 2'b11);
    idle(16);

    // R5: back-to-back and overlapping windows at shortest latency
    phaseTag = "R5";
    casLat = 4'd5;
    issue(CMD_READ, 2'b10);
    issue(CMD_READ, 2'b01);
    issue(CMD_TOFF, 2'b10);
    idle(3);
    issue(CMD_READ, 2'b10);
    idle(1);
    issue(CMD_TOFF, 2'b01);
    idle(20);

    // R7: latency raised while a window is pending
    phaseTag = "R7";
    casLat = 4'd5;
    issue(CMD_READ, 2'b10);
    idle(2);
    @(negedge clk);
    casLat = 4'd12;
    cmdCode = CMD_READ;
    csN = 2'b10;
    idle(22);
    issue(CMD_READ, 2'b01);
    idle(20);

    // R8: clamping of out-of-range latency
    phaseTag = "R8";
    casLat = 4'd2;
    idle(2);
    issue(CMD_READ, 2'b10);
    idle(20);
    casLat = 4'd15;
    idle(2);
    issue(CMD_TOFF, 2'b10);
    idle(20);

    // R9: reset in the middle of a window
    phaseTag = "R9";
    casLat = 4'd6;
    issue(CMD_READ, 2'b10);
    idle(6);
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    @(negedge clk);
    rstN = 1'b1;
    idle(15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule